// File: doc/BRIEF.md
# Proximity Interrupt Mode Controller

This block turns a stream of 16-bit proximity results into one active-low interrupt line. It also produces three active-low status flags. A 3-bit mode field selects what the interrupt line shows:

- **Comparator with hysteresis.** The line tracks whether the result is above a high threshold or below a low threshold, and holds its state in between.
- **Sticky wake-up.** The line latches on the first result above the high threshold. It stays latched until wake-up mode is left.
- **Data-ready.** The line reports that a new result is waiting. It clears when the host starts reading the first result byte.

The surrounding chip supplies four inputs:

- a one-cycle pulse with each new result and its value;
- the two thresholds;
- a one-cycle pulse when a read of the first result byte starts;
- a level that is high while a host read is in progress.

In data-ready mode, a result can arrive while a read is in progress or while the previous result is still unread. In that case the line gives a strobe of `PULSE_CYC` system clocks instead of a held level. If data is never collected, each later result therefore produces one short strobe.

Top module: `prox_irq_ctrl`

## Requirements
- R1: During and right after reset, `irq_n`, `drdy_n`, `wake_n` and `cmp_n` are all 1. The comparator state is cleared.
- R2: Only three `mode` codes select a behaviour: 3'b100 (data-ready), 3'b010 (comparator) and 3'b001 (wake-up). Any other code, including 3'b000, holds `irq_n` at 1.
- R3: A result whose value is strictly greater than `thr_hi` sets the comparator state in the cycle after `res_valid`. A set state shows as `cmp_n` = 0, and as `irq_n` = 0 in comparator mode.
- R4: A result strictly below `thr_lo` clears the comparator state in the cycle after `res_valid`. A result that is neither above `thr_hi` nor below `thr_lo` (equality included) leaves the state unchanged. If both conditions are true, "above" wins.
- R5: In wake-up mode, a result above `thr_hi` drives `irq_n` and `wake_n` to 0 from the next cycle. Both stay 0 whatever later results are, for as long as `mode` stays 3'b001.
- R6: In any cycle in which `mode` is not 3'b001, the wake-up latch clears. From the next cycle `wake_n` is 1, and a new trigger is needed to latch it again.
- R7: A data-ready level starts when a result arrives with `rd_busy` = 0 and no unread result pending. The level then holds `irq_n` low in data-ready mode until the cycle after `rd_first`.
- R8: A result arriving with `rd_busy` = 1 instead starts a strobe. The strobe holds `irq_n` low in data-ready mode for exactly `PULSE_CYC` clocks and then releases it.
- R9: A result arriving while an earlier result is still unread also starts a strobe of `PULSE_CYC` clocks, not a held level.
- R10: `drdy_n` goes to 0 in the cycle after any `res_valid`, in every mode. It returns to 1 in the cycle after an `rd_first` that has no `res_valid` alongside it. When both arrive together, the new result wins.
- R11: `cmp_n` follows the comparator state in every mode, not only in comparator mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_valid | input | 1 | One-cycle pulse with each new proximity result |
| res_value | input | W | Proximity result value |
| thr_hi | input | W | High threshold |
| thr_lo | input | W | Low threshold |
| rd_first | input | 1 | One-cycle pulse: a read of the first result byte has started |
| rd_busy | input | 1 | High while a host read is in progress |
| mode | input | 3 | Interrupt mode select |
| irq_n | output | 1 | Interrupt, active low |
| drdy_n | output | 1 | Status: 0 when an unread result is waiting |
| wake_n | output | 1 | Status: 0 when wake-up has triggered |
| cmp_n | output | 1 | Status: 0 when the comparator state is set (value was above the high threshold) |

## Verification
Every state change lands in the first cycle after the edge that samples `res_valid` or `rd_first`. `mode` steers `irq_n` with no register in between, so a mode change shows on `irq_n` in the same cycle. The bench drives inputs 1 ns after a rising edge and advances its reference state at the following edge. It compares all four outputs 1 ns after that edge, once the design has settled. Strobe length is measured by counting the clocks during which `irq_n` stays low after the triggering result, and comparing that count with `PULSE_CYC`.

// File: rtl/prox_irq_ctrl.sv
module prox_irq_ctrl #(
  parameter int W = 16,
  parameter int PULSE_CYC = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         res_valid,
  input  logic [W-1:0] res_value,
  input  logic [W-1:0] thr_hi,
  input  logic [W-1:0] thr_lo,
  input  logic         rd_first,
  input  logic         rd_busy,
  input  logic [2:0]   mode,
  output logic         irq_n,
  output logic         drdy_n,
  output logic         wake_n,
  output logic         cmp_n
);
  localparam int CW = $clog2(PULSE_CYC + 1);
  localparam logic [2:0] M_DRDY = 3'b100;
  localparam logic [2:0] M_CMP  = 3'b010;
  localparam logic [2:0] M_WAKE = 3'b001;
  localparam logic [CW-1:0] STROBE_LEN = CW'(PULSE_CYC);

  logic          cmp_q, wake_q, pend_q, lvl_q;
  logic [CW-1:0] cnt_q;

  wire above   = res_value > thr_hi;
  wire below   = res_value < thr_lo;
  wire drdy_on = lvl_q | (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= 1'b0;
      wake_q <= 1'b0;
      pend_q <= 1'b0;
      lvl_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (res_valid) begin
        if (above)      cmp_q <= 1'b1;
        else if (below) cmp_q <= 1'b0;
      end

      wake_q <= (mode == M_WAKE) && (wake_q || (res_valid && above));

      if (res_valid)     pend_q <= 1'b1;
      else if (rd_first) pend_q <= 1'b0;

      if (res_valid) begin
        if (rd_busy || pend_q) begin
          lvl_q <= 1'b0;
          cnt_q <= STROBE_LEN;
        end else begin
          lvl_q <= 1'b1;
          cnt_q <= '0;
        end
      end else begin
        if (rd_first)      lvl_q <= 1'b0;
        if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_comb begin
    case (mode)
      M_DRDY:  irq_n = ~drdy_on;
      M_CMP:   irq_n = ~cmp_q;
      M_WAKE:  irq_n = ~wake_q;
      default: irq_n = 1'b1;
    endcase
  end

  assign drdy_n = ~pend_q;
  assign wake_n = ~wake_q;
  assign cmp_n  = ~cmp_q;
endmodule

// File: rtl/prox_irq_ctrl_chk.sv
module prox_irq_ctrl_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         res_valid,
  input logic [W-1:0] res_value,
  input logic [W-1:0] thr_hi,
  input logic [W-1:0] thr_lo,
  input logic         rd_first,
  input logic [2:0]   mode,
  input logic         irq_n,
  input logic         drdy_n,
  input logic         wake_n,
  input logic         cmp_n
);
  always_comb begin
    if (!rst_n) begin
      a_r1_reset_idle: assert (irq_n && drdy_n && wake_n && cmp_n);
    end
  end

  a_r2_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'b100 && mode != 3'b010 && mode != 3'b001) |-> irq_n);

  a_r3_above_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_value > thr_hi) |=> !cmp_n);

  a_r4_below_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_value < thr_lo && !(res_value > thr_hi)) |=> cmp_n);

  a_r4_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> $stable(cmp_n));

  a_r5_wake_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b001 && !irq_n) |=> (mode != 3'b001 || !irq_n));

  a_r6_wake_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'b001) |=> wake_n);

  a_r10_result_flags: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !drdy_n);

  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_first && !res_valid) |=> drdy_n);
endmodule

bind prox_irq_ctrl prox_irq_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_value(res_value),
  .thr_hi(thr_hi), .thr_lo(thr_lo), .rd_first(rd_first), .mode(mode),
  .irq_n(irq_n), .drdy_n(drdy_n), .wake_n(wake_n), .cmp_n(cmp_n)
);

// File: tb/tb_prox_irq_ctrl.sv
module tb_prox_irq_ctrl;
  localparam int W = 16;
  localparam int PULSE_CYC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic res_valid = 1'b0, rd_first = 1'b0, rd_busy = 1'b0;
  logic [W-1:0] res_value = '0, thr_hi = 16'hA000, thr_lo = 16'h4000;
  logic [2:0] mode = 3'b000;
  logic irq_n, drdy_n, wake_n, cmp_n;

  int errors = 0, checks = 0;
  bit m_cmp, m_wake, m_pend, m_lvl;
  int m_cnt;

  always #5 clk = ~clk;

  prox_irq_ctrl #(.W(W), .PULSE_CYC(PULSE_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_value(res_value),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .rd_first(rd_first), .rd_busy(rd_busy),
    .mode(mode), .irq_n(irq_n), .drdy_n(drdy_n), .wake_n(wake_n), .cmp_n(cmp_n)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  function automatic bit exp_irq_n();
    case (mode)
      3'b100:  return !(m_lvl || m_cnt != 0);
      3'b010:  return !m_cmp;
      3'b001:  return !m_wake;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string irq_tag();
    case (mode)
      3'b100:  return "R7/R8/R9 irq_n data-ready";
      3'b010:  return "R3/R4 irq_n comparator";
      3'b001:  return "R5 irq_n wake-up";
      default: return "R2 irq_n disabled";
    endcase
  endfunction

  task automatic model_edge();
    bit above, below;
    above = res_value > thr_hi;
    below = res_value < thr_lo;
    if (res_valid) begin
      if (above) m_cmp = 1;
      else if (below) m_cmp = 0;
    end
    m_wake = (mode == 3'b001) && (m_wake || (res_valid && above));
    if (res_valid) begin
      if (rd_busy || m_pend) begin m_lvl = 0; m_cnt = PULSE_CYC; end
      else begin m_lvl = 1; m_cnt = 0; end
    end else begin
      if (rd_first) m_lvl = 0;
      if (m_cnt != 0) m_cnt--;
    end
    if (res_valid) m_pend = 1;
    else if (rd_first) m_pend = 0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    model_edge();
    chk(irq_tag(), irq_n, exp_irq_n());
    chk("R10 drdy_n", drdy_n, !m_pend);
    chk("R6 wake_n", wake_n, !m_wake);
    chk("R11 cmp_n", cmp_n, !m_cmp);
    res_valid = 0;
    rd_first = 0;
  endtask

  task automatic result(logic [W-1:0] v);
    res_valid = 1;
    res_value = v;
    step();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    int lowcnt;
    seed = 32'h5EED;
    void'($urandom(seed));
    repeat (2) @(posedge clk);
    #1;
    chk("R1 irq_n reset", irq_n, 1'b1);
    chk("R1 drdy_n reset", drdy_n, 1'b1);
    chk("R1 wake_n reset", wake_n, 1'b1);
    chk("R1 cmp_n reset", cmp_n, 1'b1);
    rst_n = 1;
    step();

    // R3/R4: hysteresis, equality holds
    mode = 3'b010;
    thr_lo = 16'd100;
    thr_hi = 16'd200;
    result(16'd250); chk("R3 above sets", irq_n, 1'b0);
    result(16'd150); chk("R4 hold between", irq_n, 1'b0);
    result(16'd200); chk("R4 equal hi holds", irq_n, 1'b0);
    result(16'd50);  chk("R4 below clears", irq_n, 1'b1);
    result(16'd100); chk("R4 equal lo holds", irq_n, 1'b1);

    // R2: reserved code hides the comparator; R11 status still follows
    result(16'd300);
    mode = 3'b110;
    step();
    chk("R2 reserved idle", irq_n, 1'b1);
    chk("R11 cmp_n in reserved mode", cmp_n, 1'b0);

    // R5/R6: sticky wake-up, cleared by leaving the mode
    mode = 3'b001;
    result(16'd10);  chk("R5 no trigger yet", irq_n, 1'b1);
    result(16'd201); chk("R5 wake triggered", irq_n, 1'b0);
    result(16'd0);   chk("R5 sticky after low value", wake_n, 1'b0);
    mode = 3'b000;
    step();
    chk("R6 wake cleared", wake_n, 1'b1);
    mode = 3'b001;
    step();
    chk("R6 needs new trigger", irq_n, 1'b1);

    // R7: level until read, R10 status
    mode = 3'b100;
    rd_first = 1;
    step();
    result(16'd5);
    chk("R7 level low", irq_n, 1'b0);
    step();
    step();
    chk("R7 level held", irq_n, 1'b0);
    rd_first = 1;
    step();
    chk("R7 released by read", irq_n, 1'b1);
    chk("R10 status cleared by read", drdy_n, 1'b1);

    // R8: strobe width when a read is in progress
    rd_busy = 1;
    res_valid = 1;
    step();
    rd_busy = 0;
    lowcnt = 0;
    while (irq_n == 1'b0 && lowcnt < 20) begin
      lowcnt++;
      step();
    end
    chk("R8 strobe length ok", lowcnt == PULSE_CYC, 1'b1);
    if (lowcnt != PULSE_CYC)
      $display("FAIL R8 strobe actual=%0d expected=%0d", lowcnt, PULSE_CYC);

    // R9: unread data -> strobe; R10 tie result wins
    result(16'd1);
    lowcnt = 0;
    while (irq_n == 1'b0 && lowcnt < 20) begin
      lowcnt++;
      step();
    end
    chk("R9 unread strobe length ok", lowcnt == PULSE_CYC, 1'b1);
    chk("R9 still pending", drdy_n, 1'b0);
    res_valid = 1;
    rd_first = 1;
    step();
    chk("R10 simultaneous result wins", drdy_n, 1'b0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 49) == 0) begin
        case ($urandom_range(0, 5))
          0: mode = 3'b100;
          1: mode = 3'b010;
          2: mode = 3'b001;
          3: mode = 3'b000;
          default: mode = 3'($urandom_range(0, 7));
        endcase
      end
      if ($urandom_range(0, 199) == 0) begin
        thr_hi = 16'($urandom);
        thr_lo = 16'($urandom);
      end
      res_valid = ($urandom_range(0, 3) == 0);
      res_value = 16'($urandom);
      rd_first = ($urandom_range(0, 7) == 0);
      rd_busy = ($urandom_range(0, 2) == 0);
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule